// File: doc/BRIEF.md
# USB Interrupt Cause Detector

This block sits beside the protocol engine of a USB controller that can act as host or as peripheral. It watches the VBUS pin, the two-bit line state, a suspended flag and a set of single-cycle event strobes from the transaction logic. From these it sets one sticky status bit per interrupt cause. Each cause follows its own trigger rule and is accepted only in the role it belongs to.

Every status bit has an enable. One active-high interrupt line is raised while any enabled status bit is set. Software clears bits by writing ones to them. The asynchronous pins (VBUS and line state) are synchronized before edges are detected. Edge detection is held off until the synchronizer and the previous-value register hold real samples, so leaving reset never creates an event.

Top module: `usb_irq_detect`

## Requirements
- R1: Status bit 0 (VBUS) sets on every level change of the synchronized VBUS input, rising or falling, in host and in peripheral mode.
- R2: Status bit 4 (bus change) sets whenever the synchronized two-bit line state takes a new value, in either mode.
- R3: Status bit 1 (resume) sets only when `host_mode_i`=0, `suspended_i`=1, the previous line state is J and the new one is K or SE0. The line codes are SE0=00, J=01, K=10, SE1=11.
- R4: In host mode (`host_mode_i`=1), status bit 2 (frame refresh) sets on an `sof_stb_i` whose `sof_frame_i` differs from the frame of the last strobe. The first strobe after reset always counts as different.
- R5: In peripheral mode with `sof_sel_i`=0, bit 2 sets on an `sof_stb_i` carrying a new frame number. With `sof_sel_i`=1, bit 2 sets only on `sof_bad_i`. In no other case does `sof_bad_i` set bit 2.
- R6: In peripheral mode, status bit 3 (device state) sets when any bit of `dev_evt_i` is high. Bit 0 is bus reset, bit 1 is suspend entry, bit 2 is the address request and bit 3 is the configuration request.
- R7: In host mode, `setup_ack_i` sets status bit 5 (setup done) and `setup_nak_i` sets status bit 6 (setup error).
- R8: A cause that belongs to the other mode leaves its status bit unchanged.
- R9: A clear write (`clr_wr_i`=1) zeroes every status bit whose `clr_data_i` bit is 1. If a cause arrives in the same cycle, the set takes priority. A cause arriving while its bit is already set keeps the bit set.
- R10: `irq_o` is a register of the OR of (status AND `irq_en_i`). It rises one cycle after an enabled bit is set and falls one cycle after the last enabled bit clears.
- R11: After reset all status bits and `irq_o` are 0. A pin level present at reset release produces no event. A pin change reaches the status bits three clock edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_mode_i | input | 1 | 1 = host role, 0 = peripheral role |
| sof_sel_i | input | 1 | Peripheral frame-refresh rule: 0 = new frame number, 1 = corrupted SOF |
| vbus_i | input | 1 | Raw VBUS pin level |
| line_i | input | 2 | Raw line state (SE0=00, J=01, K=10, SE1=11) |
| suspended_i | input | 1 | Bus is in the suspended state |
| sof_stb_i | input | 1 | Strobe: an SOF was sent (host) or received (peripheral) |
| sof_frame_i | input | FRAME_W | Frame number that goes with `sof_stb_i` |
| sof_bad_i | input | 1 | Strobe: a corrupted SOF was detected |
| dev_evt_i | input | DEV_N | Device-state event strobes |
| setup_ack_i | input | 1 | Strobe: a setup transaction was acknowledged |
| setup_nak_i | input | 1 | Strobe: a setup transaction got no acknowledge |
| irq_en_i | input | 7 | Per-bit interrupt enables |
| clr_wr_i | input | 1 | Clear write strobe |
| clr_data_i | input | 7 | Ones clear the matching status bits |
| status_o | output | 7 | Sticky status bits |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its default parameters: an 11-bit frame number, four device-event strobes and a two-stage synchronizer. With the two-bit line state, all sixteen from/to line transitions can be swept in both roles and with the suspended flag both low and high. Every SOF kind (repeated frame, new frame, corrupted) is crossed with both roles and both frame-refresh rules, and each device-event and setup strobe is tried in both roles. The interrupt timing, the clear priority and the reset-release behaviour are probed cycle by cycle.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int N_CAUSE   = 7;
  localparam int B_VBUS    = 0;
  localparam int B_RESUME  = 1;
  localparam int B_FRAME   = 2;
  localparam int B_DEVST   = 3;
  localparam int B_BUSCHG  = 4;
  localparam int B_SETOK   = 5;
  localparam int B_SETERR  = 6;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_e;
endpackage

// File: rtl/uirq_sync.sv
module uirq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_n;
    if (s == 0) begin : g_first
      always_comb stg_n = d_i;
    end else begin : g_next
      always_comb stg_n = stg_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) stg_q[s] <= '0;
      else          stg_q[s] <= stg_n;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/uirq_edge.sv
module uirq_edge #(
  parameter int SYNC_STAGES = 2,
  parameter int LS_W        = 2
) (
  input  logic            clk_i,
  input  logic            rst_n_i,
  input  logic            vbus_s_i,
  input  logic [LS_W-1:0] line_s_i,
  output logic            vbus_chg_o,
  output logic            line_chg_o,
  output logic [LS_W-1:0] line_prev_o
);
  localparam int ARM_D = SYNC_STAGES + 1;

  logic [ARM_D-1:0] arm_q, arm_n;
  logic             vbus_prev_q, vbus_prev_n;
  logic [LS_W-1:0]  line_prev_q, line_prev_n;
  logic             armed;

  always_comb begin
    arm_n       = {arm_q[ARM_D-2:0], 1'b1};
    vbus_prev_n = vbus_s_i;
    line_prev_n = line_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      arm_q       <= '0;
      vbus_prev_q <= 1'b0;
      line_prev_q <= '0;
    end else begin
      arm_q       <= arm_n;
      vbus_prev_q <= vbus_prev_n;
      line_prev_q <= line_prev_n;
    end
  end

  assign armed       = arm_q[ARM_D-1];
  assign vbus_chg_o  = armed && (vbus_s_i != vbus_prev_q);
  assign line_chg_o  = armed && (line_s_i != line_prev_q);
  assign line_prev_o = line_prev_q;

  p_vbus_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    vbus_chg_o |-> (vbus_s_i != $past(vbus_s_i)));
  p_line_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    line_chg_o |-> (line_s_i != $past(line_s_i)));
endmodule

// File: rtl/uirq_cause.sv
module uirq_cause
  import uirq_pkg::*;
#(
  parameter int FRAME_W = 11,
  parameter int DEV_N   = 4,
  parameter int LS_W    = 2
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               host_mode_i,
  input  logic               sof_sel_i,
  input  logic               suspended_i,
  input  logic               vbus_chg_i,
  input  logic               line_chg_i,
  input  logic [LS_W-1:0]    line_prev_i,
  input  logic [LS_W-1:0]    line_now_i,
  input  logic               sof_stb_i,
  input  logic [FRAME_W-1:0] sof_frame_i,
  input  logic               sof_bad_i,
  input  logic [DEV_N-1:0]   dev_evt_i,
  input  logic               setup_ack_i,
  input  logic               setup_nak_i,
  output logic [N_CAUSE-1:0] set_o
);
  logic [FRAME_W-1:0] last_frame_q, last_frame_n;
  logic               have_frame_q, have_frame_n;
  logic               frame_new;
  logic               periph;
  logic               resume_hit;
  logic               frame_hit;

  assign periph    = !host_mode_i;
  assign frame_new = sof_stb_i && (!have_frame_q || (sof_frame_i != last_frame_q));

  always_comb begin
    last_frame_n = last_frame_q;
    have_frame_n = have_frame_q;
    if (sof_stb_i) begin
      last_frame_n = sof_frame_i;
      have_frame_n = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      last_frame_q <= '0;
      have_frame_q <= 1'b0;
    end else begin
      last_frame_q <= last_frame_n;
      have_frame_q <= have_frame_n;
    end
  end

  always_comb begin
    resume_hit = periph && suspended_i && line_chg_i &&
                 (line_prev_i == LS_J) &&
                 ((line_now_i == LS_K) || (line_now_i == LS_SE0));
    if (host_mode_i)     frame_hit = frame_new;
    else if (sof_sel_i)  frame_hit = sof_bad_i;
    else                 frame_hit = frame_new;
  end

  always_comb begin
    set_o           = '0;
    set_o[B_VBUS]   = vbus_chg_i;
    set_o[B_RESUME] = resume_hit;
    set_o[B_FRAME]  = frame_hit;
    set_o[B_DEVST]  = periph && (|dev_evt_i);
    set_o[B_BUSCHG] = line_chg_i;
    set_o[B_SETOK]  = host_mode_i && setup_ack_i;
    set_o[B_SETERR] = host_mode_i && setup_nak_i;
  end

  p_resume_cond_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    set_o[B_RESUME] |-> (suspended_i && !host_mode_i && line_chg_i));
  p_frame_bad_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (set_o[B_FRAME] && !host_mode_i && sof_sel_i) |-> sof_bad_i);
  p_devst_periph_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    set_o[B_DEVST] |-> (!host_mode_i && (dev_evt_i != '0)));
  p_setup_host_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (set_o[B_SETOK] || set_o[B_SETERR]) |-> host_mode_i);
endmodule

// File: rtl/uirq_status.sv
module uirq_status #(
  parameter int N = 7
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [N-1:0] set_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] clr_data_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] status_q, status_n;
  logic         irq_q, irq_n;
  logic [N-1:0] clr_mask;

  assign clr_mask = clr_wr_i ? clr_data_i : '0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb status_n[i] = set_i[i] | (status_q[i] & ~clr_mask[i]);
  end

  always_comb irq_n = |(status_q & en_i);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_n;
      irq_q    <= irq_n;
    end
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    clr_wr_i |=> ((status_q & $past(clr_data_i & ~set_i)) == '0));
  p_irq_hi_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ((status_q & en_i) != '0) |=> irq_q);
  p_irq_lo_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ((status_q & en_i) == '0) |=> !irq_q);
endmodule

// File: rtl/usb_irq_detect.sv
module usb_irq_detect
  import uirq_pkg::*;
#(
  parameter int FRAME_W     = 11,
  parameter int DEV_N       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               host_mode_i,
  input  logic               sof_sel_i,
  input  logic               vbus_i,
  input  logic [1:0]         line_i,
  input  logic               suspended_i,
  input  logic               sof_stb_i,
  input  logic [FRAME_W-1:0] sof_frame_i,
  input  logic               sof_bad_i,
  input  logic [DEV_N-1:0]   dev_evt_i,
  input  logic               setup_ack_i,
  input  logic               setup_nak_i,
  input  logic [6:0]         irq_en_i,
  input  logic               clr_wr_i,
  input  logic [6:0]         clr_data_i,
  output logic [6:0]         status_o,
  output logic               irq_o
);
  localparam int LS_W  = 2;
  localparam int PIN_W = LS_W + 1;

  logic [1:0]         rst_sync_q;
  logic               rst_q;
  logic [PIN_W-1:0]   pins_s;
  logic               vbus_chg, line_chg;
  logic [LS_W-1:0]    line_prev;
  logic [N_CAUSE-1:0] set_vec;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  uirq_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_q),
    .d_i     ({vbus_i, line_i}),
    .q_o     (pins_s)
  );

  uirq_edge #(.SYNC_STAGES(SYNC_STAGES), .LS_W(LS_W)) u_edge (
    .clk_i       (clk_i),
    .rst_n_i     (rst_q),
    .vbus_s_i    (pins_s[PIN_W-1]),
    .line_s_i    (pins_s[LS_W-1:0]),
    .vbus_chg_o  (vbus_chg),
    .line_chg_o  (line_chg),
    .line_prev_o (line_prev)
  );

  uirq_cause #(.FRAME_W(FRAME_W), .DEV_N(DEV_N), .LS_W(LS_W)) u_cause (
    .clk_i       (clk_i),
    .rst_n_i     (rst_q),
    .host_mode_i (host_mode_i),
    .sof_sel_i   (sof_sel_i),
    .suspended_i (suspended_i),
    .vbus_chg_i  (vbus_chg),
    .line_chg_i  (line_chg),
    .line_prev_i (line_prev),
    .line_now_i  (pins_s[LS_W-1:0]),
    .sof_stb_i   (sof_stb_i),
    .sof_frame_i (sof_frame_i),
    .sof_bad_i   (sof_bad_i),
    .dev_evt_i   (dev_evt_i),
    .setup_ack_i (setup_ack_i),
    .setup_nak_i (setup_nak_i),
    .set_o       (set_vec)
  );

  uirq_status #(.N(N_CAUSE)) u_status (
    .clk_i      (clk_i),
    .rst_n_i    (rst_q),
    .set_i      (set_vec),
    .clr_wr_i   (clr_wr_i),
    .clr_data_i (clr_data_i),
    .en_i       (irq_en_i),
    .status_o   (status_o),
    .irq_o      (irq_o)
  );

  p_quiet_after_reset_r11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !rst_q |=> (status_o == '0 && !irq_o));
endmodule

// File: tb/usb_irq_detect_test.sv
module usb_irq_detect_test;
  localparam int FW = 11;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_mode, sof_sel, vbus, suspended;
  logic [1:0]    line;
  logic          sof_stb, sof_bad, setup_ack, setup_nak, clr_wr;
  logic [FW-1:0] sof_frame;
  logic [3:0]    dev_evt;
  logic [6:0]    irq_en, clr_data, status;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  usb_irq_detect uut (
    .clk_i(clk), .rst_n_i(rst_n), .host_mode_i(host_mode), .sof_sel_i(sof_sel),
    .vbus_i(vbus), .line_i(line), .suspended_i(suspended), .sof_stb_i(sof_stb),
    .sof_frame_i(sof_frame), .sof_bad_i(sof_bad), .dev_evt_i(dev_evt),
    .setup_ack_i(setup_ack), .setup_nak_i(setup_nak), .irq_en_i(irq_en),
    .clr_wr_i(clr_wr), .clr_data_i(clr_data), .status_o(status), .irq_o(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    clr_wr = 1'b1; clr_data = 7'h7f;
    tick(1);
    clr_wr = 1'b0; clr_data = 7'h00;
    tick(1);
  endtask

  task automatic sof(input logic [FW-1:0] f, input logic bad, input logic stb);
    sof_frame = f; sof_bad = bad; sof_stb = stb;
    tick(1);
    sof_bad = 1'b0; sof_stb = 1'b0;
    tick(2);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_mode = 1'b0; sof_sel = 1'b0; vbus = 1'b1; suspended = 1'b0;
    line = 2'b01; sof_stb = 1'b0; sof_bad = 1'b0; sof_frame = '0; dev_evt = '0;
    setup_ack = 1'b0; setup_nak = 1'b0; irq_en = '0; clr_wr = 1'b0; clr_data = '0;
    tick(3);
    rst_n = 1'b1;
    tick(8);
    // R11: reset state, pin levels present at release raise nothing
    check("R11 status after reset", status, 0);
    check("R11 irq after reset", irq, 0);

    // R1 / R11: VBUS both edges, both modes, pin-to-status latency
    for (int m = 0; m < 2; m++) begin
      for (int e = 0; e < 2; e++) begin
        host_mode = m[0];
        vbus = ~vbus;
        tick(2);
        check("R11 latency not yet", status[0], 0);
        tick(1);
        check("R1 vbus edge", status[0], 1);
        clear_all();
      end
    end

    // R2 / R3 / R8: all line transitions x mode x suspended
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 2; s++) begin
        for (int f = 0; f < 4; f++) begin
          for (int t = 0; t < 4; t++) begin
            logic exp_res;
            host_mode = m[0]; suspended = s[0];
            line = f[1:0];
            tick(5);
            clear_all();
            line = t[1:0];
            tick(5);
            exp_res = (m == 0) && (s == 1) && (f == 1) && (t == 2 || t == 0);
            check("R2 bus change", status[4], (f != t) ? 1 : 0);
            check("R3 resume", status[1], exp_res);
            check("R8 others idle", status & 7'b1101101, 0);
          end
        end
      end
    end
    suspended = 1'b0; line = 2'b01;
    tick(5);
    clear_all();

    // R4 / R5 / R8: SOF kinds x mode x rule select
    for (int m = 0; m < 2; m++) begin
      for (int sl = 0; sl < 2; sl++) begin
        for (int k = 0; k < 3; k++) begin
          logic exp_f;
          host_mode = m[0]; sof_sel = sl[0];
          sof(11'd5, 1'b0, 1'b1);
          clear_all();
          if (k == 0)      sof(11'd5, 1'b0, 1'b1);
          else if (k == 1) sof(11'd6, 1'b0, 1'b1);
          else             sof(11'd5, 1'b1, 1'b0);
          if (m == 1)       exp_f = (k == 1);
          else if (sl == 0) exp_f = (k == 1);
          else              exp_f = (k == 2);
          check(m == 1 ? "R4 host frame" : "R5 periph frame", status[2], exp_f);
          clear_all();
        end
      end
    end
    sof_sel = 1'b0;

    // R6 / R7 / R8: strobes in both modes
    for (int m = 0; m < 2; m++) begin
      host_mode = m[0];
      for (int b = 0; b < 4; b++) begin
        dev_evt = 4'b1 << b;
        tick(1);
        dev_evt = '0;
        tick(2);
        check("R6 device state", status[3], (m == 0) ? 1 : 0);
        clear_all();
      end
      setup_ack = 1'b1; tick(1); setup_ack = 1'b0; tick(2);
      check("R7 setup ok", status, (m == 1) ? 7'h20 : 7'h00);
      clear_all();
      setup_nak = 1'b1; tick(1); setup_nak = 1'b0; tick(2);
      check("R7 setup error", status, (m == 1) ? 7'h40 : 7'h00);
      clear_all();
    end

    // R9: set wins over clear, repeat set stays, partial clear
    host_mode = 1'b1;
    setup_ack = 1'b1; clr_wr = 1'b1; clr_data = 7'h20;
    tick(1);
    setup_ack = 1'b0; clr_wr = 1'b0; clr_data = '0;
    tick(1);
    check("R9 set beats clear", status[5], 1);
    setup_ack = 1'b1; tick(1); setup_ack = 1'b0; tick(1);
    check("R9 repeat set", status[5], 1);
    setup_nak = 1'b1; tick(1); setup_nak = 1'b0; tick(1);
    clr_wr = 1'b1; clr_data = 7'h40; tick(1); clr_wr = 1'b0; clr_data = '0;
    check("R9 selective clear", status, 7'h20);
    clear_all();

    // R10: irq timing and masking
    irq_en = 7'h40;
    setup_ack = 1'b1; tick(1); setup_ack = 1'b0; tick(2);
    check("R10 masked bit", irq, 0);
    irq_en = 7'h20;
    tick(1);
    check("R10 enable raises", irq, 1);
    clear_all();
    setup_nak = 1'b1; irq_en = 7'h40;
    tick(1);
    setup_nak = 1'b0;
    check("R10 status first", {status[6], irq}, 2'b10);
    tick(1);
    check("R10 irq next", irq, 1);
    clr_wr = 1'b1; clr_data = 7'h40;
    tick(1);
    clr_wr = 1'b0; clr_data = '0;
    check("R10 irq lags clear", {status[6], irq}, 2'b01);
    tick(1);
    check("R10 irq falls", irq, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule